// File: doc/BRIEF.md
# Measurement Mode and Rate Scheduler

This block decides when a magnetometer measurement sequencer is launched. It reads the stored 2-bit operating mode and 3-bit output-rate code, counts a prescaled timebase tick, and issues a one-cycle start strobe to the sequencer. When the sequencer reports completion with its done strobe, the scheduler either waits for the next rate period or, in one-shot operation, asks the register storage to overwrite the mode field with an idle code.

In free-running operation the first launch is held back by two output periods after reset or after any write to the mode or configuration register. Later launches follow once per period. In idle operation nothing is launched and a power-down flag switches off the analog front end. Register access is not affected by this flag. The register storage sits outside the block: it presents the stored codes and pulses a write strobe in the same cycle as a new value appears.

Top module: `mag_sched`

## Requirements
- R1: Mode code 00 selects free-running, 01 selects one-shot, and 10 and 11 both select idle. With mode 01 held at reset release, `seq_start` pulses in the first cycle after the first clock edge following release.
- R2: In one-shot mode exactly one `seq_start` pulse is issued per entry into the mode (reset release or a `mode_wr`), and none follows until the next `mode_wr`.
- R3: One clock after `seq_done` ends a one-shot cycle, `mode_upd` pulses for one cycle with `mode_upd_val` = 11.
- R4: While the mode code is 10 or 11 and no cycle is running, `pwr_down` is high and no `seq_start` is issued.
- R5: The period in timebase ticks per rate code is 000:200, 001:100, 010:50, 011:20, 100:10, 101:5, 110:2, and the reserved code 111 behaves like 110 (2 ticks).
- R6: In free-running mode the first `seq_start` follows the 2P-th tick after a `mode_wr` or `cfg_wr`, where P is the period of the rate code presented with the write. Each later start follows P ticks after the previous due tick. The start appears two clocks after the due tick.
- R7: A `mode_wr` during a running cycle lets that cycle finish, discards any scheduled free-running restart (timing restarts at 2P), and cancels the idle write-back of a one-shot cycle.
- R8: `seq_start` is one cycle wide and is never issued while a cycle is running. A `seq_done` outside a cycle has no effect.
- R9: During reset `seq_start` and `mode_upd` are low, and `pwr_down` follows the presented mode code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_code | input | 2 | Stored operating mode code |
| rate_code | input | 3 | Stored output-rate code |
| mode_wr | input | 1 | Mode register written this cycle |
| cfg_wr | input | 1 | Configuration register written this cycle |
| seq_done | input | 1 | Sequencer finished its cycle |
| tick | input | 1 | Prescaled timebase pulse |
| seq_start | output | 1 | Launch one measurement cycle |
| mode_upd | output | 1 | Request to overwrite the stored mode field |
| mode_upd_val | output | 2 | Value to write with `mode_upd` |
| pwr_down | output | 1 | Power down the analog front end |

## Verification
On every cycle the assertions check that launches are single pulses that never overlap a running cycle, that an idle code never produces a launch, and that every write-back request directly follows a done strobe and carries the idle code. The rate periods, the two-period delay after a write, and the discarding of a scheduled restart or write-back are counts of ticks across whole scenarios, so only the bench's directed runs can show them. The same holds for the rule of one launch per one-shot entry.

// File: rtl/mag_sched.sv
module mag_sched #(
  parameter int unsigned P_R0 = 200,
  parameter int unsigned P_R1 = 100,
  parameter int unsigned P_R2 = 50,
  parameter int unsigned P_R3 = 20,
  parameter int unsigned P_R4 = 10,
  parameter int unsigned P_R5 = 5,
  parameter int unsigned P_R6 = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_code,
  input  logic [2:0] rate_code,
  input  logic       mode_wr,
  input  logic       cfg_wr,
  input  logic       seq_done,
  input  logic       tick,
  output logic       seq_start,
  output logic       mode_upd,
  output logic [1:0] mode_upd_val,
  output logic       pwr_down
);

  function automatic int unsigned mx(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  localparam int unsigned PMAX = mx(mx(mx(P_R0, P_R1), mx(P_R2, P_R3)), mx(mx(P_R4, P_R5), P_R6));
  localparam int CW = $clog2(2 * PMAX + 1);
  localparam logic [1:0] IDLE_CODE = 2'b11;

  function automatic logic [CW-1:0] period(input logic [2:0] rc);
    case (rc)
      3'd0:    return CW'(P_R0);
      3'd1:    return CW'(P_R1);
      3'd2:    return CW'(P_R2);
      3'd3:    return CW'(P_R3);
      3'd4:    return CW'(P_R4);
      3'd5:    return CW'(P_R5);
      default: return CW'(P_R6);
    endcase
  endfunction

  logic          busy, armed, pend, single_run;
  logic [CW-1:0] cnt;

  wire [CW-1:0] per_sel   = period(rate_code);
  wire          wr        = mode_wr | cfg_wr;
  wire          is_cont   = (mode_code == 2'b00);
  wire          is_single = (mode_code == 2'b01);
  wire          fire_s    = (armed | mode_wr) & is_single & ~busy;
  wire          fire_c    = pend & ~wr & is_cont & ~busy;
  wire          fire      = fire_s | fire_c;
  wire          due       = tick & is_cont & ~wr & (cnt <= CW'(1));

  assign mode_upd_val = IDLE_CODE;
  assign pwr_down     = mode_code[1] & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      armed      <= 1'b1;
      pend       <= 1'b0;
      single_run <= 1'b0;
      seq_start  <= 1'b0;
      mode_upd   <= 1'b0;
      cnt        <= CW'(2 * P_R4);
    end else begin
      seq_start <= fire;
      mode_upd  <= seq_done & busy & single_run & ~mode_wr;

      if (fire)          busy <= 1'b1;
      else if (seq_done) busy <= 1'b0;

      if (fire_s)       armed <= 1'b0;
      else if (mode_wr) armed <= 1'b1;

      if (fire_s)                   single_run <= 1'b1;
      else if (seq_done | mode_wr)  single_run <= 1'b0;

      if (wr)          pend <= 1'b0;
      else if (due)    pend <= 1'b1;
      else if (fire_c) pend <= 1'b0;

      if (wr)                  cnt <= per_sel << 1;
      else if (tick & is_cont) cnt <= (cnt <= CW'(1)) ? per_sel : cnt - CW'(1);
    end
  end

endmodule

module mag_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_code,
  input logic       seq_done,
  input logic       seq_start,
  input logic       mode_upd,
  input logic [1:0] mode_upd_val,
  input logic       busy
);

  assert_start_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start);

  assert_no_start_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> !$past(busy));

  assert_idle_no_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code[1] |=> !seq_start);

  assert_upd_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_upd |-> $past(seq_done));

  assert_upd_idle_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_upd |-> (mode_upd_val == 2'b11));

  assert_upd_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_upd |=> !mode_upd);

endmodule

bind mag_sched mag_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .seq_done(seq_done),
  .seq_start(seq_start), .mode_upd(mode_upd), .mode_upd_val(mode_upd_val), .busy(busy)
);

// File: tb/mag_sched_bench.sv
module mag_sched_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_code = 2'b01;
  logic [2:0] rate_code = 3'b100;
  logic       mode_wr = 1'b0, cfg_wr = 1'b0, seq_done = 1'b0, tick = 1'b0;
  logic       seq_start, mode_upd, pwr_down;
  logic [1:0] mode_upd_val;

  always #2 clk = ~clk;

  mag_sched u_mag_sched (
    .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .rate_code(rate_code),
    .mode_wr(mode_wr), .cfg_wr(cfg_wr), .seq_done(seq_done), .tick(tick),
    .seq_start(seq_start), .mode_upd(mode_upd), .mode_upd_val(mode_upd_val),
    .pwr_down(pwr_down)
  );

  int nchk = 0, nfail = 0;
  int nsteps = 0, tdiv = 0, tick_cnt = 0, cd = 0;
  int nstart = 0, nupd = 0, upd_step = -1, done_step = -2, dbl = 0;
  logic [1:0] mreg = 2'b01;
  logic [1:0] req_v = 2'b00;
  logic [2:0] req_r = 3'b100;
  bit busy_m = 0, saw_start = 0, saw_upd = 0, prev_start = 0;
  bit req_m = 0, req_c = 0, req_d = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    nsteps++;
    saw_start = seq_start;
    saw_upd   = mode_upd;
    if (seq_start && prev_start) dbl++;
    prev_start = seq_start;
    if (seq_start) begin nstart++; busy_m = 1; cd = 3; end
    if (mode_upd) begin nupd++; mreg = mode_upd_val; upd_step = nsteps; end
    mode_wr = 0; cfg_wr = 0; seq_done = 0;
    if (busy_m) begin
      if (cd == 0) begin seq_done = 1; busy_m = 0; done_step = nsteps; end
      else cd--;
    end
    if (req_d) begin seq_done = 1; req_d = 0; end
    tdiv = (tdiv + 1) % 4;
    tick = (tdiv == 0);
    if (tick) tick_cnt++;
    if (req_m) begin mreg = req_v; mode_wr = 1; req_m = 0; tick_cnt = 0; end
    if (req_c) begin rate_code = req_r; cfg_wr = 1; req_c = 0; tick_cnt = 0; end
    mode_code = mreg;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wait_start(input int lim, output bit found);
    found = 0;
    for (int i = 0; i < lim && !found; i++) begin
      step();
      found = saw_start;
    end
  endtask

  task automatic settle_idle();
    req_v = 2'b10; req_m = 1;
    run(12);
  endtask

  task automatic t_reset_single();
    bit f;
    run(3);
    chk(seq_start == 0, "R9 start in reset", seq_start, 0);
    chk(mode_upd == 0, "R9 upd in reset", mode_upd, 0);
    chk(pwr_down == 0, "R9 pwr_down in reset", pwr_down, 0);
    rst_n = 1;
    step();
    chk(saw_start, "R1 single start after reset", saw_start, 1);
    f = 0;
    for (int i = 0; i < 20 && !f; i++) begin step(); f = saw_upd; end
    chk(f, "R3 write-back issued", f, 1);
    chk(upd_step == done_step + 1, "R3 write-back one clock after done", upd_step - done_step, 1);
    chk(mreg == 2'b11, "R3 write-back value", mreg, 3);
    run(2);
    chk(pwr_down == 1, "R4 pwr_down after one-shot", pwr_down, 1);
    run(200);
    chk(nstart == 1, "R2 single start count", nstart, 1);
  endtask

  task automatic t_idle();
    int s0;
    req_v = 2'b10; req_m = 1;
    s0 = nstart;
    run(200);
    chk(nstart == s0, "R4 no start in idle code 10", nstart - s0, 0);
    chk(pwr_down == 1, "R1 code 10 is idle", pwr_down, 1);
    req_d = 1;
    run(3);
    chk(nupd == 1 && pwr_down == 1, "R8 stray done ignored", nupd, 1);
  endtask

  task automatic t_cont(input logic [2:0] rc, input int p, input string tag);
    bit f;
    int t1;
    req_r = rc; req_c = 1; req_v = 2'b00; req_m = 1;
    wait_start(4 * (2 * p + 4) + 8, f);
    chk(f && tick_cnt == 2 * p, {tag, " first start at 2P ticks"}, tick_cnt, 2 * p);
    t1 = tick_cnt;
    wait_start(4 * (p + 4) + 8, f);
    chk(f && tick_cnt - t1 == p, {tag, " period in ticks"}, tick_cnt - t1, p);
    chk(mreg == 2'b00, "R6 mode field kept in free-running", mreg, 0);
    settle_idle();
  endtask

  task automatic t_wr_during();
    bit f;
    req_r = 3'b101; req_c = 1; req_v = 2'b00; req_m = 1;
    wait_start(80, f);
    req_v = 2'b00; req_m = 1;
    wait_start(80, f);
    chk(f && tick_cnt == 10, "R7 restart discarded on mode write", tick_cnt, 10);
    settle_idle();
  endtask

  task automatic t_single_cancel();
    bit f;
    int u0;
    u0 = nupd;
    req_v = 2'b01; req_m = 1;
    wait_start(10, f);
    chk(f, "R2 single start on mode write", f, 1);
    req_v = 2'b10; req_m = 1;
    run(20);
    chk(nupd == u0, "R7 write-back cancelled", nupd - u0, 0);
    chk(mreg == 2'b10 && pwr_down == 1, "R7 cycle finished, idle kept", mreg, 2);
  endtask

  task automatic t_cfg_restart();
    bit f;
    req_r = 3'b101; req_c = 1; req_v = 2'b00; req_m = 1;
    wait_start(80, f);
    while (tick_cnt < 13) step();
    req_r = 3'b110; req_c = 1;
    wait_start(60, f);
    chk(f && tick_cnt == 4, "R6 cfg write restarts at 2P", tick_cnt, 4);
    settle_idle();
  endtask

  task automatic run_all();
    t_reset_single();
    t_idle();
    t_cont(3'b101, 5,   "R6 R5 rate 101");
    t_cont(3'b111, 2,   "R5 reserved 111");
    t_cont(3'b110, 2,   "R5 rate 110");
    t_cont(3'b100, 10,  "R5 rate 100");
    t_cont(3'b011, 20,  "R5 rate 011");
    t_cont(3'b000, 200, "R5 rate 000");
    t_wr_during();
    t_single_cancel();
    t_cfg_restart();
    chk(dbl == 0, "R8 start one cycle wide", dbl, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        #(150000 * 4);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule